// File: doc/BRIEF.md
# Endian-Selectable Byte Lane Packer

The block moves data between a byte-wide stream and a word made of four byte lanes. On the inbound path it gathers successive stream bytes into a word and offers that word to the wide side. On the outbound path it accepts a word from the wide side and sends its lanes out one byte at a time. Both paths use valid/ready handshakes. All transfers start on a word boundary.

A single order-select input sets which lane is filled first and which lane is sent first. Low selects little-endian order, with lane 0 first and lanes in ascending order. High selects big-endian order, with the top lane first and lanes in descending order. The select is captured once per word, so changing it partway through a word does not affect that word.

The same rule also sets how an 8-bit external memory maps onto the lanes. Bytes at four consecutive offsets are steered onto the lanes in both directions.

Top module: `lane_packer`

## Requirements
- R1: With order_sel low (little), the first inbound byte of a word lands in lane 0 and later bytes fill lanes 1, 2, 3. Lane k is bits [8k+7:8k] of a word.
- R2: With order_sel high (big), the first inbound byte lands in lane 3 and later bytes fill lanes 2, 1, 0.
- R3: With order_sel low, an outbound word is sent on the byte stream as lane 0, then lane 1, lane 2 and lane 3.
- R4: With order_sel high, an outbound word is sent as lane 3, then lane 2, lane 1 and lane 0.
- R5: External memory read: mem_rd_data offset k occupies bits [8k+7:8k]. With order_sel low, offset k appears on lane k of mem_rd_word. With order_sel high, offset k appears on lane 3-k.
- R6: External memory write: with order_sel low, lane k of mem_wr_word goes to offset k of mem_wr_data. With order_sel high, lane 3-k goes to offset k.
- R7: order_sel is captured when the first byte of an inbound word is taken, or when an outbound word is accepted. A change later in that word has no effect on its lane order.
- R8: in_word_valid rises one cycle after the fourth byte is accepted. in_word_valid and in_word_data then stay unchanged until in_word_ready takes the word.
- R9: While a completed inbound word waits and has not been taken, in_byte_ready is low.
- R10: After an outbound word is accepted, out_word_ready stays low until all four of its bytes have been taken on the byte side.
- R11: Synchronous active-high reset clears both paths. No partial word gathered before reset is ever presented afterwards. After reset, in_byte_ready and out_word_ready are high and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| order_sel | input | 1 | Lane order: 0 little, 1 big |
| in_byte_valid | input | 1 | Inbound byte offered |
| in_byte_ready | output | 1 | Inbound byte can be taken |
| in_byte_data | input | 8 | Inbound byte |
| in_word_valid | output | 1 | Gathered word available |
| in_word_ready | input | 1 | Wide side takes the gathered word |
| in_word_data | output | 32 | Gathered word |
| out_word_valid | input | 1 | Outbound word offered |
| out_word_ready | output | 1 | Outbound word can be taken |
| out_word_data | input | 32 | Outbound word |
| out_byte_valid | output | 1 | Outbound byte available |
| out_byte_ready | input | 1 | Byte side takes the byte |
| out_byte_data | output | 8 | Outbound byte |
| mem_rd_data | input | 32 | Bytes read from memory, offset k at bits [8k+7:8k] |
| mem_rd_word | output | 32 | Read bytes steered onto lanes |
| mem_wr_word | input | 32 | Word to be written to memory |
| mem_wr_data | output | 32 | Bytes per memory offset, offset k at bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: four lanes of eight bits. This lets every lane position be checked against a 2-bit position counter in both orders, including the wrap from lane 3 back to lane 0 between words. Throttled ready patterns on the wide inbound side and the outbound byte side create back-pressure at every lane position. A forced hold on the inbound word exposes the byte-side stall. The select is flipped partway through a word, and reset is applied partway through a word.

// File: rtl/lane_pkg.sv
package lane_pkg;

    typedef enum logic {
        ORD_LITTLE = 1'b0,
        ORD_BIG    = 1'b1
    } byte_order_e;

    // Lane that holds stream position pos for the given order.
    function automatic int lane_index(input int pos, input byte_order_e ord, input int nlanes);
        return (ord == ORD_BIG) ? (nlanes - 1 - pos) : pos;
    endfunction

endpackage

// File: rtl/lane_fill.sv
module lane_fill
    import lane_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    order_sel,
    input  logic                    b_valid,
    output logic                    b_ready,
    input  logic [BYTE_W-1:0]       b_data,
    output logic                    w_valid,
    input  logic                    w_ready,
    output logic [LANES*BYTE_W-1:0] w_data
);
    localparam int CW     = $clog2(LANES);
    localparam int WORD_W = LANES * BYTE_W;

    logic [CW-1:0]     pos_q;
    byte_order_e       ord_q;
    byte_order_e       ord_now;
    logic              full_q;
    logic [WORD_W-1:0] word_q;
    logic [CW-1:0]     lane;
    logic              take_b;
    logic              take_w;

    // The select is live only for the first byte of a word.
    assign ord_now = (pos_q == '0) ? byte_order_e'(order_sel) : ord_q;
    assign lane    = CW'(lane_index(int'(pos_q), ord_now, LANES));
    assign b_ready = !full_q;
    assign take_b  = b_valid && b_ready;
    assign take_w  = full_q && w_ready;
    assign w_valid = full_q;
    assign w_data  = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            ord_q  <= ORD_LITTLE;
            full_q <= 1'b0;
            word_q <= '0;
        end else begin
            if (take_w) begin
                full_q <= 1'b0;
            end
            if (take_b) begin
                word_q[lane*BYTE_W +: BYTE_W] <= b_data;
                ord_q <= ord_now;
                if (pos_q == CW'(LANES - 1)) begin
                    pos_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    // R8: a waiting word holds still until taken
    a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
        (w_valid && !w_ready) |=> (w_valid && $stable(w_data)));

    // R9: byte side is stalled while a word waits
    a_r9_byte_stall: assert property (@(posedge clk) disable iff (rst)
        (w_valid && !w_ready) |=> !b_ready);

    // R8: taking the word frees the byte side
    a_r8_word_taken: assert property (@(posedge clk) disable iff (rst)
        (w_valid && w_ready) |=> (!w_valid && b_ready));

    // R11: reset leaves nothing pending
    a_r11_fill_reset: assert property (@(posedge clk)
        rst |=> (!w_valid && b_ready));

endmodule

// File: rtl/lane_drain.sv
module lane_drain
    import lane_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    order_sel,
    input  logic                    w_valid,
    output logic                    w_ready,
    input  logic [LANES*BYTE_W-1:0] w_data,
    output logic                    b_valid,
    input  logic                    b_ready,
    output logic [BYTE_W-1:0]       b_data
);
    localparam int CW     = $clog2(LANES);
    localparam int WORD_W = LANES * BYTE_W;

    logic [CW-1:0]     pos_q;
    byte_order_e       ord_q;
    logic              busy_q;
    logic [WORD_W-1:0] word_q;
    logic [CW-1:0]     lane;

    assign lane    = CW'(lane_index(int'(pos_q), ord_q, LANES));
    assign w_ready = !busy_q;
    assign b_valid = busy_q;
    assign b_data  = word_q[lane*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            ord_q  <= ORD_LITTLE;
            busy_q <= 1'b0;
            word_q <= '0;
        end else if (w_valid && w_ready) begin
            word_q <= w_data;
            ord_q  <= byte_order_e'(order_sel);
            pos_q  <= '0;
            busy_q <= 1'b1;
        end else if (b_valid && b_ready) begin
            if (pos_q == CW'(LANES - 1)) begin
                busy_q <= 1'b0;
                pos_q  <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // R10: an accepted word blocks the next one while it drains
    a_r10_word_block: assert property (@(posedge clk) disable iff (rst)
        (w_valid && w_ready) |=> (b_valid && !w_ready));

    // R10: an untaken byte holds still
    a_r10_byte_hold: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_data)));

    // R11: reset leaves the byte side idle
    a_r11_drain_reset: assert property (@(posedge clk)
        rst |=> (!b_valid && w_ready));

endmodule

// File: rtl/lane_mem_map.sv
module lane_mem_map
    import lane_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    order_sel,
    input  logic [LANES*BYTE_W-1:0] rd_data,
    output logic [LANES*BYTE_W-1:0] rd_word,
    input  logic [LANES*BYTE_W-1:0] wr_word,
    output logic [LANES*BYTE_W-1:0] wr_data
);
    byte_order_e ord;
    assign ord = byte_order_e'(order_sel);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int MIR = LANES - 1 - k;
        // Offset k feeds lane k (little) or lane LANES-1-k (big); the mapping is its own inverse.
        assign rd_word[k*BYTE_W +: BYTE_W] = (ord == ORD_BIG) ? rd_data[MIR*BYTE_W +: BYTE_W]
                                                              : rd_data[k*BYTE_W +: BYTE_W];
        assign wr_data[k*BYTE_W +: BYTE_W] = (ord == ORD_BIG) ? wr_word[MIR*BYTE_W +: BYTE_W]
                                                              : wr_word[k*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/lane_packer.sv
module lane_packer
    import lane_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    order_sel,
    input  logic                    in_byte_valid,
    output logic                    in_byte_ready,
    input  logic [BYTE_W-1:0]       in_byte_data,
    output logic                    in_word_valid,
    input  logic                    in_word_ready,
    output logic [LANES*BYTE_W-1:0] in_word_data,
    input  logic                    out_word_valid,
    output logic                    out_word_ready,
    input  logic [LANES*BYTE_W-1:0] out_word_data,
    output logic                    out_byte_valid,
    input  logic                    out_byte_ready,
    output logic [BYTE_W-1:0]       out_byte_data,
    input  logic [LANES*BYTE_W-1:0] mem_rd_data,
    output logic [LANES*BYTE_W-1:0] mem_rd_word,
    input  logic [LANES*BYTE_W-1:0] mem_wr_word,
    output logic [LANES*BYTE_W-1:0] mem_wr_data
);

    lane_fill #(.LANES(LANES), .BYTE_W(BYTE_W)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .order_sel (order_sel),
        .b_valid   (in_byte_valid),
        .b_ready   (in_byte_ready),
        .b_data    (in_byte_data),
        .w_valid   (in_word_valid),
        .w_ready   (in_word_ready),
        .w_data    (in_word_data)
    );

    lane_drain #(.LANES(LANES), .BYTE_W(BYTE_W)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .order_sel (order_sel),
        .w_valid   (out_word_valid),
        .w_ready   (out_word_ready),
        .w_data    (out_word_data),
        .b_valid   (out_byte_valid),
        .b_ready   (out_byte_ready),
        .b_data    (out_byte_data)
    );

    lane_mem_map #(.LANES(LANES), .BYTE_W(BYTE_W)) u_mem (
        .order_sel (order_sel),
        .rd_data   (mem_rd_data),
        .rd_word   (mem_rd_word),
        .wr_word   (mem_wr_word),
        .wr_data   (mem_wr_data)
    );

endmodule

// File: tb/lane_packer_bench.sv
`timescale 1ns/1ps
module lane_packer_bench;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WW     = LANES * BYTE_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic order_sel = 1'b0;
    logic in_byte_valid = 1'b0;
    logic in_byte_ready;
    logic [BYTE_W-1:0] in_byte_data = '0;
    logic in_word_valid;
    logic in_word_ready;
    logic [WW-1:0] in_word_data;
    logic out_word_valid = 1'b0;
    logic out_word_ready;
    logic [WW-1:0] out_word_data = '0;
    logic out_byte_valid;
    logic out_byte_ready;
    logic [BYTE_W-1:0] out_byte_data;
    logic [WW-1:0] mem_rd_data = '0;
    logic [WW-1:0] mem_rd_word;
    logic [WW-1:0] mem_wr_word = '0;
    logic [WW-1:0] mem_wr_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int pat = 0;
    logic hold_wr = 1'b0;
    logic [WW-1:0]     exp_words[$];
    logic [BYTE_W-1:0] exp_bytes[$];

    always #2.5 clk = ~clk;

    lane_packer #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lane_packer (
        .clk(clk), .rst(rst), .order_sel(order_sel),
        .in_byte_valid(in_byte_valid), .in_byte_ready(in_byte_ready), .in_byte_data(in_byte_data),
        .in_word_valid(in_word_valid), .in_word_ready(in_word_ready), .in_word_data(in_word_data),
        .out_word_valid(out_word_valid), .out_word_ready(out_word_ready), .out_word_data(out_word_data),
        .out_byte_valid(out_byte_valid), .out_byte_ready(out_byte_ready), .out_byte_data(out_byte_data),
        .mem_rd_data(mem_rd_data), .mem_rd_word(mem_rd_word),
        .mem_wr_word(mem_wr_word), .mem_wr_data(mem_wr_data)
    );

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Throttled ready patterns, changed away from the active edge.
    always @(negedge clk) begin
        pat <= pat + 1;
        cyc <= cyc + 1;
    end
    assign in_word_ready  = !hold_wr && (pat % 3 != 0);
    assign out_byte_ready = (pat % 4 != 1);

    // Monitor: samples just before each rising edge.
    always begin
        @(negedge clk);
        #2;
        if (!rst && in_word_valid && in_word_ready) begin
            if (exp_words.size() == 0) check("R11 unexpected word", in_word_data, '0);
            else check("R1/R2/R7/R8 inbound word", in_word_data, exp_words.pop_front());
        end
        if (!rst && out_byte_valid) begin
            check("R10 word ready low while draining", WW'(out_word_ready), '0);
            if (out_byte_ready) begin
                if (exp_bytes.size() == 0) check("R11 unexpected byte", WW'(out_byte_data), '0);
                else check("R3/R4/R7 outbound byte", WW'(out_byte_data), WW'(exp_bytes.pop_front()));
            end
        end
    end

    // Watchdog
    initial begin
        wait (cyc > 100000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        finish_run();
    end

    // Called at a falling edge; returns at a falling edge after the byte is taken.
    task automatic push_byte(input logic [BYTE_W-1:0] d);
        in_byte_valid = 1'b1;
        in_byte_data  = d;
        #2;
        while (!in_byte_ready) begin
            @(negedge clk);
            #2;
        end
        @(negedge clk);
        in_byte_valid = 1'b0;
    endtask

    // flip: invert order_sel after the first byte (R7).
    task automatic send_word(input logic [WW-1:0] bytes_in, input logic big, input logic flip);
        logic [WW-1:0] e;
        for (int k = 0; k < LANES; k++) begin
            int ln = big ? LANES - 1 - k : k;
            e[ln*BYTE_W +: BYTE_W] = bytes_in[k*BYTE_W +: BYTE_W];
        end
        exp_words.push_back(e);
        order_sel = big;
        for (int k = 0; k < LANES; k++) begin
            push_byte(bytes_in[k*BYTE_W +: BYTE_W]);
            if (flip && k == 0) order_sel = !big;
        end
    endtask

    task automatic send_out(input logic [WW-1:0] w, input logic big, input logic flip);
        order_sel      = big;
        out_word_valid = 1'b1;
        out_word_data  = w;
        #2;
        while (!out_word_ready) begin
            @(negedge clk);
            #2;
        end
        for (int k = 0; k < LANES; k++) begin
            int ln = big ? LANES - 1 - k : k;
            exp_bytes.push_back(w[ln*BYTE_W +: BYTE_W]);
        end
        @(negedge clk);
        out_word_valid = 1'b0;
        if (flip) order_sel = !big;
    endtask

    task automatic mem_check(input logic big);
        logic [WW-1:0] er;
        logic [WW-1:0] ew;
        order_sel   = big;
        mem_rd_data = 32'h44_33_22_11;
        mem_wr_word = 32'hDD_CC_BB_AA;
        for (int k = 0; k < LANES; k++) begin
            int ln = big ? LANES - 1 - k : k;
            er[ln*BYTE_W +: BYTE_W] = mem_rd_data[k*BYTE_W +: BYTE_W];
            ew[k*BYTE_W +: BYTE_W]  = mem_wr_word[ln*BYTE_W +: BYTE_W];
        end
        #1;
        check("R5 memory read lanes", mem_rd_word, er);
        check("R6 memory write offsets", mem_wr_data, ew);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R11 reset in_word_valid", WW'(in_word_valid), '0);
        check("R11 reset out_byte_valid", WW'(out_byte_valid), '0);
        check("R11 reset in_byte_ready", WW'(in_byte_ready), 1);
        check("R11 reset out_word_ready", WW'(out_word_ready), 1);
        @(negedge clk);

        // R1, R2 inbound fill orders
        send_word(32'h04_03_02_01, 1'b0, 1'b0);
        send_word(32'h14_13_12_11, 1'b1, 1'b0);
        send_word(32'hA4_A3_A2_A1, 1'b0, 1'b0);
        send_word(32'hB4_B3_B2_B1, 1'b1, 1'b0);
        // R7 mid-word select change
        send_word(32'hC4_C3_C2_C1, 1'b1, 1'b1);
        send_word(32'hD4_D3_D2_D1, 1'b0, 1'b1);

        // R9 stall with word waiting
        wait (exp_words.size() == 0);
        @(negedge clk);
        hold_wr = 1'b1;
        send_word(32'hE4_E3_E2_E1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        #2;
        check("R8 word valid after fourth byte", WW'(in_word_valid), 1);
        check("R9 byte ready low while word waits", WW'(in_byte_ready), '0);
        @(negedge clk);
        hold_wr = 1'b0;
        wait (exp_words.size() == 0);
        @(negedge clk);

        // R11 reset drops a partial word
        order_sel = 1'b0;
        push_byte(8'h55);
        push_byte(8'h66);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R11 no word after reset", WW'(in_word_valid), '0);
        @(negedge clk);
        send_word(32'h7A_79_78_77, 1'b0, 1'b0);
        wait (exp_words.size() == 0);
        @(negedge clk);

        // R3, R4 outbound orders, R7 via flip during drain
        send_out(32'h44_33_22_11, 1'b0, 1'b0);
        send_out(32'h88_77_66_55, 1'b1, 1'b0);
        send_out(32'hCC_BB_AA_99, 1'b0, 1'b1);
        send_out(32'hF0_E0_D0_C0, 1'b1, 1'b1);
        send_out(32'h0D_0C_0B_0A, 1'b0, 1'b0);
        wait (exp_bytes.size() == 0);
        repeat (2) @(negedge clk);

        // R5, R6 memory mapping
        mem_check(1'b0);
        mem_check(1'b1);

        check("R1/R3 scoreboard drained", WW'(exp_words.size() + exp_bytes.size()), '0);
        finish_run();
    end

endmodule